// File: doc/BRIEF.md
# Two-Rank Shift Register with Pulse Sequencer

This block holds a data word in an upper bank of toggles and has a lower bank of the same width beside it. Gated transfer paths link the two banks. Every transfer into a bank is paired with a clear of that bank. The clear and the transfer start in the same cycle, and the transfer stays active for longer than the clear. While the transfer is active, ones from the source are ORed into the cleared destination, so when the transfer ends the destination holds the source value.

One shift step is made of two phases. In the first, the upper bank is copied down into the lower bank. In the second, the lower bank is moved back up into the upper bank, offset by one place toward the MSB (left) or toward the LSB (right). The bit that is vacated is filled with zero. A sequencer counts the requested steps with a 6-bit counter and then pulses `done`. The sequencer also runs a parallel load, which clears the upper bank and moves external data into it.

The pulse widths are given in clock cycles. A clear lasts `CLR_CYC` cycles. A transfer lasts `CLR_CYC + EXT_CYC` cycles, called one phase of `P` cycles. With the defaults, P is 3.

Top module: `twoRankShifter`

## Requirements
- R1: After reset, both banks are all zero and `busy` and `done` are low.
- R2: `loadEn` high while idle with `start` low loads `loadData` into the upper bank within one phase, then pulses `done`. The lower bank keeps its value. `loadData` must stay steady until `done`.
- R3: Each clear is paired with a transfer into the same bank. Both start in the same cycle, the clear lasts CLR_CYC cycles and the transfer lasts CLR_CYC+EXT_CYC cycles. A load therefore takes exactly P cycles from its accepting edge to `done`.
- R4: Each shift step first copies the upper bank into the lower bank. After a shift of N>0 steps, the lower bank holds the value from before the last step.
- R5: With `dirLeft`=1, a shift of N steps moves the upper bank N places toward the MSB and fills with zeros.
- R6: With `dirLeft`=0, a shift of N steps moves the upper bank N places toward the LSB and fills with zeros.
- R7: `done` rises 2·P·N cycles after the edge that accepts `start`. It is high for exactly one cycle, and `busy` is low while it is high.
- R8: A `shiftCount` of 0 raises `done` right after the accepting edge and leaves both banks unchanged.
- R9: While `busy` is high, `start` and `loadEn` are ignored. Their direction, count and data have no effect on the result or the timing.
- R10: The largest count, 63, performs 63 steps.
- R11: When `start` and `loadEn` are both high while idle, the shift is performed and the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a shift (sampled while idle) |
| dirLeft | input | 1 | 1 = toward MSB, 0 = toward LSB |
| shiftCount | input | 6 | Number of shift steps, 0 to 63 |
| loadEn | input | 1 | Request a parallel load into the upper bank |
| loadData | input | 40 | Parallel load value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| upperQ | output | 40 | Upper bank contents |
| lowerQ | output | 40 | Lower bank contents |

## Verification
The assertions check the gate pulses on every cycle. Each clear comes with its transfer, no transfer ends before its clear, at most one transfer path is open at a time, and at the end of every phase the destination bank equals the shifted or copied source. They also check that `done` is a single pulse and that the direction stays frozen while busy. Only the bench scenarios can show end-to-end results and latencies across many steps, the zero and maximum counts, and that requests made mid-operation are dropped. The start-over-load priority is also shown only by the bench.

// File: rtl/trsPkg.sv
package trsPkg;
  typedef struct packed {
    logic clrUpper;
    logic clrLower;
    logic xDown;
    logic xLeft;
    logic xRight;
    logic xIn;
  } gateStrobes_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_IN   = 2'd1,
    S_DOWN = 2'd2,
    S_BACK = 2'd3
  } seqState_t;
endpackage

// File: rtl/trsBanks.sv
module trsBanks
  import trsPkg::*;
#(
  parameter int WIDTH = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  gateStrobes_t     gates,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] upperQ,
  output logic [WIDTH-1:0] lowerQ
);
  logic [WIDTH-1:0] upSrc;
  logic [WIDTH-1:0] downSrc;

  // per-stage gating: each upper toggle sees its right or left lower neighbour,
  // or the external bit; each lower toggle sees its upper partner
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic fromRight;
    logic fromLeft;
    if (i == 0) begin : g_lsb
      assign fromRight = 1'b0;
    end else begin : g_mid_r
      assign fromRight = lowerQ[i-1];
    end
    if (i == WIDTH - 1) begin : g_msb
      assign fromLeft = 1'b0;
    end else begin : g_mid_l
      assign fromLeft = lowerQ[i+1];
    end
    assign upSrc[i] = (gates.xLeft & fromRight) | (gates.xRight & fromLeft)
                    | (gates.xIn & loadData[i]);
    assign downSrc[i] = gates.xDown & upperQ[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperQ <= '0;
      lowerQ <= '0;
    end else begin
      if (gates.clrUpper) upperQ <= '0;
      else                upperQ <= upperQ | upSrc;
      if (gates.clrLower) lowerQ <= '0;
      else                lowerQ <= lowerQ | downSrc;
    end
  end

  // R4: when a down transfer ends, the lower bank mirrors the upper bank
  p_down_copy_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gates.xDown) |-> (lowerQ == upperQ));
  // R5: when a left transfer ends, upper is lower moved toward MSB, zero fill
  p_left_move_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gates.xLeft) |-> (upperQ == {lowerQ[WIDTH-2:0], 1'b0}));
  // R6: when a right transfer ends, upper is lower moved toward LSB, zero fill
  p_right_move_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gates.xRight) |-> (upperQ == {1'b0, lowerQ[WIDTH-1:1]}));
  // R2: when a load transfer ends, upper holds the held load value
  p_load_value_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gates.xIn) |-> (upperQ == $past(loadData)));
endmodule

// File: rtl/trsSequencer.sv
module trsSequencer
  import trsPkg::*;
#(
  parameter int CNT_W   = 6,
  parameter int CLR_CYC = 2,
  parameter int EXT_CYC = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             dirLeft,
  input  logic [CNT_W-1:0] shiftCount,
  input  logic             loadEn,
  output gateStrobes_t     gates,
  output logic             busy,
  output logic             done
);
  localparam int PHASE = CLR_CYC + EXT_CYC;
  localparam int PH_W  = $clog2(PHASE + 1);

  seqState_t        state;
  logic [PH_W-1:0]  phaseCnt;
  logic [CNT_W-1:0] stepsLeft;
  logic             dirReg;
  logic             phaseLast;
  logic             clrWindow;

  assign phaseLast = (phaseCnt == PH_W'(PHASE - 1));
  assign clrWindow = (phaseCnt < PH_W'(CLR_CYC));
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      phaseCnt  <= '0;
      stepsLeft <= '0;
      dirReg    <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          phaseCnt <= '0;
          if (start) begin
            if (shiftCount == '0) begin
              done <= 1'b1;
            end else begin
              state     <= S_DOWN;
              stepsLeft <= shiftCount;
              dirReg    <= dirLeft;
            end
          end else if (loadEn) begin
            state <= S_IN;
          end
        end
        S_IN: begin
          if (phaseLast) begin
            state    <= S_IDLE;
            phaseCnt <= '0;
            done     <= 1'b1;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        S_DOWN: begin
          if (phaseLast) begin
            state    <= S_BACK;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        S_BACK: begin
          if (phaseLast) begin
            phaseCnt <= '0;
            if (stepsLeft == CNT_W'(1)) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              state     <= S_DOWN;
              stepsLeft <= stepsLeft - 1'b1;
            end
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    gates = '0;
    unique case (state)
      S_IN: begin
        gates.clrUpper = clrWindow;
        gates.xIn      = 1'b1;
      end
      S_DOWN: begin
        gates.clrLower = clrWindow;
        gates.xDown    = 1'b1;
      end
      S_BACK: begin
        gates.clrUpper = clrWindow;
        gates.xLeft    = dirReg;
        gates.xRight   = !dirReg;
      end
      default: gates = '0;
    endcase
  end

  // R3: a clear of a bank only ever comes with a transfer into that bank
  p_clear_paired_r3: assert property (@(posedge clk) disable iff (!rstN)
    (gates.clrUpper |-> (gates.xLeft | gates.xRight | gates.xIn)) and
    (gates.clrLower |-> gates.xDown));
  // R3: the transfer is still active in the cycle after its clear ends
  p_xfer_outlasts_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gates.clrUpper) |-> (gates.xLeft | gates.xRight | gates.xIn));
  p_xfer_outlasts_lo_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gates.clrLower) |-> gates.xDown);
  // R3: one transfer path at a time
  p_one_path_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({gates.xDown, gates.xLeft, gates.xRight, gates.xIn}));
  // R7: done is a single-cycle pulse and never overlaps busy
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R8: a zero count finishes on the next edge without going busy
  p_zero_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && shiftCount == '0) |=> (done && !busy));
  // R9: direction is frozen for the whole shift
  p_dir_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && state != S_IN) |=> (!busy || $stable(dirReg)));
  // R10: a step in progress always has a nonzero remaining count
  p_steps_live_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DOWN || state == S_BACK) |-> (stepsLeft != '0));
endmodule

// File: rtl/twoRankShifter.sv
module twoRankShifter
  import trsPkg::*;
#(
  parameter int WIDTH   = 40,
  parameter int CNT_W   = 6,
  parameter int CLR_CYC = 2,
  parameter int EXT_CYC = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             dirLeft,
  input  logic [CNT_W-1:0] shiftCount,
  input  logic             loadEn,
  input  logic [WIDTH-1:0] loadData,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] upperQ,
  output logic [WIDTH-1:0] lowerQ
);
  gateStrobes_t gates;

  trsSequencer #(
    .CNT_W  (CNT_W),
    .CLR_CYC(CLR_CYC),
    .EXT_CYC(EXT_CYC)
  ) u_seq (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .dirLeft   (dirLeft),
    .shiftCount(shiftCount),
    .loadEn    (loadEn),
    .gates     (gates),
    .busy      (busy),
    .done      (done)
  );

  trsBanks #(
    .WIDTH(WIDTH)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .gates   (gates),
    .loadData(loadData),
    .upperQ  (upperQ),
    .lowerQ  (lowerQ)
  );

  // R1: banks stay empty while nothing has been loaded since reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy) && !done) |-> $stable(upperQ) && $stable(lowerQ));
endmodule

// File: tb/sim_twoRankShifter.sv
`timescale 1ns/1ps
module sim_twoRankShifter;
  localparam int W  = 40;
  localparam int CW = 6;
  localparam int P  = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          dirLeft = 1'b0;
  logic [CW-1:0] shiftCount = '0;
  logic          loadEn = 1'b0;
  logic [W-1:0]  loadData = '0;
  logic          busy, done;
  logic [W-1:0]  upperQ, lowerQ;

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;
  logic [W-1:0] mUp = '0;
  logic [W-1:0] mLo = '0;

  always #2.5 clk = ~clk;

  twoRankShifter u0 (
    .clk(clk), .rstN(rstN), .start(start), .dirLeft(dirLeft),
    .shiftCount(shiftCount), .loadEn(loadEn), .loadData(loadData),
    .busy(busy), .done(done), .upperQ(upperQ), .lowerQ(lowerQ)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nChk++; nFail++;
      $display("FAIL R7 watchdog: act=%0d cycles exp<=150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] moveBy(input logic [W-1:0] v, input int n,
                                          input bit left);
    return left ? (v << n) : (v >> n);
  endfunction

  task automatic waitDone(output int lat, input bit inject);
    lat = 0;
    while (!done && lat < 2000) begin
      if (inject && lat == 2) begin
        check(busy == 1'b1, "R9 busy at injection", 64'(busy), 64'd1);
        start = 1'b1; loadEn = 1'b1; dirLeft = ~dirLeft;
        shiftCount = 6'd5; loadData = {W{1'b1}};
      end else if (inject && lat == 3) begin
        start = 1'b0; loadEn = 1'b0;
      end
      @(posedge clk); #1;
      lat++;
    end
    start = 1'b0; loadEn = 1'b0;
  endtask

  task automatic runLoad(input logic [W-1:0] d);
    int lat;
    @(negedge clk);
    loadEn = 1'b1; start = 1'b0; loadData = d;
    @(posedge clk); #1;
    loadEn = 1'b0;
    waitDone(lat, 1'b0);
    check(lat == P, "R3 load latency", 64'(lat), 64'(P));
    check(upperQ == d, "R2 upper loaded", 64'(upperQ), 64'(d));
    check(lowerQ == mLo, "R2 lower kept", 64'(lowerQ), 64'(mLo));
    mUp = d;
    @(posedge clk); #1;
    check(done == 1'b0, "R7 done single pulse", 64'(done), 64'd0);
  endtask

  task automatic runShift(input int n, input bit left, input bit inject,
                          input bit alsoLoad);
    int lat;
    logic [W-1:0] eUp, eLo;
    @(negedge clk);
    start = 1'b1; dirLeft = left; shiftCount = CW'(n);
    loadEn = alsoLoad; loadData = ~mUp;
    @(posedge clk); #1;
    start = 1'b0; loadEn = 1'b0;
    waitDone(lat, inject && n > 0);
    eUp = moveBy(mUp, n, left);
    eLo = (n == 0) ? mLo : moveBy(mUp, n - 1, left);
    check(lat == 2 * P * n, (n == 0) ? "R8 zero latency" : "R7 shift latency",
          64'(lat), 64'(2 * P * n));
    check(busy == 1'b0, "R7 idle with done", 64'(busy), 64'd0);
    check(upperQ == eUp, left ? "R5 left result" : "R6 right result",
          64'(upperQ), 64'(eUp));
    check(lowerQ == eLo, (n == 0) ? "R8 lower unchanged" : "R4 lower holds prior",
          64'(lowerQ), 64'(eLo));
    mUp = eUp; mLo = eLo;
    @(posedge clk); #1;
    check(done == 1'b0, "R7 done single pulse", 64'(done), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd20231));
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    @(posedge clk); #1;
    // R1: reset state
    check(upperQ == '0 && lowerQ == '0, "R1 banks clear", 64'(upperQ | lowerQ), 64'd0);
    check(busy == 1'b0 && done == 1'b0, "R1 flags low", {62'd0, busy, done}, 64'd0);

    runLoad(40'h80_0000_0001);
    runShift(1, 1'b1, 1'b0, 1'b0);          // R5 single step
    runShift(1, 1'b0, 1'b0, 1'b0);          // R6 single step
    runShift(0, 1'b1, 1'b0, 1'b0);          // R8 zero count
    runLoad(40'hA5_5A5A_A5A5);
    runShift(63, 1'b1, 1'b0, 1'b0);         // R10 max count left
    runLoad(40'hFF_FFFF_FFFF);
    runShift(39, 1'b0, 1'b0, 1'b0);         // R6 down to one bit
    runShift(63, 1'b0, 1'b0, 1'b0);         // R10 max count right
    runLoad(40'h12_3456_789A);
    runShift(7, 1'b1, 1'b1, 1'b0);          // R9 injection while busy
    runShift(4, 1'b0, 1'b0, 1'b1);          // R11 start wins over load

    for (int k = 0; k < 40; k++) begin
      int op;
      op = $urandom_range(0, 3);
      if (op == 0) runLoad({$urandom(), $urandom()} >> 24);
      else runShift($urandom_range(0, 63), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule